// File: doc/BRIEF.md
# Dual-Region Field CRC Engine

This block runs two 16-bit cyclic redundancy checks side by side over a stream of 10-bit video words, one word per clock. One check covers the active picture and the other covers the full field. Each has its own region enable, driven by upstream timing logic, that marks which words belong to that region. A field-end strobe closes the field: both finished check words are captured into output registers and both accumulators restart from zero for the next field.

Before any word reaches either polynomial, the values 3FCh to 3FFh are all turned into 3FFh. An 8-bit path that pads its low bits and a 10-bit path that carries them in full therefore agree on the check words. In receive mode the captured words are compared with the check words taken from the incoming error data packet, and a per-region error flag is raised on a mismatch. In transmit mode the captured words are presented for insertion into an outgoing packet and both flags are held clear.

Top module: `field_crc_pair`

## Requirements
- R1: Each check uses the polynomial x^16 + x^12 + x^5 + 1 (0x1021), preset to 0 at every field start. A word is fed in bit 0 first. For each bit b: fb = b XOR crc[15], then crc = (crc << 1) XOR (fb ? 0x1021 : 0), keeping 16 bits.
- R2: A word whose value lies in 3FCh..3FFh enters both polynomials as 3FFh. Every other value enters unchanged.
- R3: A word advances the active-picture check only when `ap_en` is 1, and the full-field check only when `ff_en` is 1. A word with its enable at 0 leaves that check unchanged.
- R4: In a cycle with `field_end` = 1, the word present in that cycle is still folded into each region whose enable is 1. The finished value appears on `ap_crc`/`ff_crc` from the next clock edge, and the next field's accumulation starts from 0.
- R5: `ap_crc`, `ff_crc`, `ap_err` and `ff_err` change only at the edge that ends a cycle with `field_end` = 1. A flag may also be cleared by `tx_mode` (R8).
- R6: In receive mode (`tx_mode` = 0), when `field_end` = 1 and a region's received-valid bit is 1, that region's error flag becomes 1 if the finished check differs from the received word, and 0 if they are equal.
- R7: When `field_end` = 1 and a region's received-valid bit is 0, that region's error flag becomes 0.
- R8: At any edge where `tx_mode` = 1, both error flags become 0. The check words are still captured at `field_end` as in R4.
- R9: After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 10 | Video word |
| ap_en | input | 1 | Word belongs to the active-picture region |
| ff_en | input | 1 | Word belongs to the full-field region |
| field_end | input | 1 | Last cycle of the field; capture and restart |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| rx_ap_crc | input | 16 | Received active-picture check word |
| rx_ap_valid | input | 1 | Received active-picture word is valid |
| rx_ff_crc | input | 16 | Received full-field check word |
| rx_ff_valid | input | 1 | Received full-field word is valid |
| ap_crc | output | 16 | Captured active-picture check of the last field |
| ff_crc | output | 16 | Captured full-field check of the last field |
| ap_err | output | 1 | Active-picture mismatch flag |
| ff_err | output | 1 | Full-field mismatch flag |

## Verification
Two functions can fall in the same cycle here. The field-end capture can meet an enabled data word. The mismatch comparison can meet a transmit-mode clear. The bench closes every one of a full sweep of 1024 one-word fields with the strobe on the only data word, so the captured value must already contain that word and the next field must restart from zero. Separately, it raises a strobe with a mismatching, valid received word while transmit mode is set, and judges that the flags read 0 while the captured words still carry the field's arithmetic result.

// File: rtl/fcrc_pkg.sv
// Package: shared sizes and region indices for the dual-region field CRC engine.
// Assumes one word per clock and two regions (active picture, full field).
package fcrc_pkg;
    localparam int DATA_W      = 10;
    localparam int CRC_W       = 16;
    localparam int NUM_REGIONS = 2;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum int {
        REGION_AP = 0,
        REGION_FF = 1
    } region_e;
endpackage

// File: rtl/fcrc_fold.sv
// Module: fcrc_fold
// Maps the top four codes of the word range onto the all-ones code, so that
// 8-bit sources that pad their low bits give the same check words as 10-bit ones.
// Assumes WIDTH >= 3. Purely combinational.
module fcrc_fold #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_out
);
    localparam int HI_W = WIDTH - 2;

    logic top_band;

    // Detect a word in the band whose upper bits are all ones
    always_comb top_band = &word_in[WIDTH-1:2];

    // Force the two low bits high inside the band
    always_comb word_out = top_band ? {word_in[WIDTH-1:2], 2'b11} : word_in;

    logic [HI_W-1:0] unused_hi;
    always_comb unused_hi = word_in[WIDTH-1:2];
endmodule

// File: rtl/fcrc_lane.sv
// Module: fcrc_lane
// One region's check path: a gated bitwise CRC accumulator, a capture register
// loaded at field end, and a receive-mode comparator for the error flag.
// Assumes word_in is already folded and field_end is a one-cycle strobe.
module fcrc_lane #(
    parameter int              DATA_W = 10,
    parameter int              CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word_in,
    input  logic              en,
    input  logic              field_end,
    input  logic              tx_mode,
    input  logic [CRC_W-1:0]  rx_crc,
    input  logic              rx_valid,
    output logic [CRC_W-1:0]  crc_q,
    output logic              err_q
);
    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] acc_nxt;

    // Advance a CRC by one word, bit 0 first
    function automatic logic [CRC_W-1:0] advance(input logic [CRC_W-1:0] c_in,
                                                 input logic [DATA_W-1:0] w);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < DATA_W; i++) begin
            fb = w[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return c;
    endfunction

    // Next accumulator value including the current word when enabled
    always_comb acc_nxt = en ? advance(acc, word_in) : acc;

    // Running accumulator, restarted from zero after field end
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (field_end) acc <= '0;
        else                acc <= acc_nxt;
    end

    // Capture the finished check word at field end
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= '0;
        else if (field_end) crc_q <= acc_nxt;
    end

    // Error flag: cleared in transmit, compared in receive at field end
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (tx_mode)   err_q <= 1'b0;
        else if (field_end) err_q <= rx_valid && (acc_nxt != rx_crc);
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !field_end) |=> $stable(acc));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_end |=> (acc == '0));

    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_end |=> ($stable(crc_q) && !$rose(err_q)));

    // R7
    invalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && !rx_valid) |=> !err_q);

    // R8
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode |=> !err_q);
endmodule

// File: rtl/field_crc_pair.sv
// Module: field_crc_pair
// Top of the dual-region field CRC engine: folds each incoming word once,
// then feeds it to one lane per region (active picture, full field).
// Assumes region enables and field_end come from upstream timing logic.
module field_crc_pair
    import fcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        din,
    input  logic              ap_en,
    input  logic              ff_en,
    input  logic              field_end,
    input  logic              tx_mode,
    input  logic [15:0]       rx_ap_crc,
    input  logic              rx_ap_valid,
    input  logic [15:0]       rx_ff_crc,
    input  logic              rx_ff_valid,
    output logic [15:0]       ap_crc,
    output logic [15:0]       ff_crc,
    output logic              ap_err,
    output logic              ff_err
);
    logic [DATA_W-1:0] folded;
    logic [NUM_REGIONS-1:0]            lane_en;
    logic [NUM_REGIONS-1:0]            lane_rx_valid;
    logic [NUM_REGIONS-1:0][CRC_W-1:0] lane_rx_crc;
    logic [NUM_REGIONS-1:0][CRC_W-1:0] lane_crc;
    logic [NUM_REGIONS-1:0]            lane_err;

    fcrc_fold #(.WIDTH(DATA_W)) u_fold (
        .word_in  (din),
        .word_out (folded)
    );

    // Gather per-region inputs into indexed vectors
    always_comb begin
        lane_en[REGION_AP]       = ap_en;
        lane_en[REGION_FF]       = ff_en;
        lane_rx_valid[REGION_AP] = rx_ap_valid;
        lane_rx_valid[REGION_FF] = rx_ff_valid;
        lane_rx_crc[REGION_AP]   = rx_ap_crc;
        lane_rx_crc[REGION_FF]   = rx_ff_crc;
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lane
        fcrc_lane #(
            .DATA_W (DATA_W),
            .CRC_W  (CRC_W),
            .POLY   (CRC_POLY)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_in   (folded),
            .en        (lane_en[g]),
            .field_end (field_end),
            .tx_mode   (tx_mode),
            .rx_crc    (lane_rx_crc[g]),
            .rx_valid  (lane_rx_valid[g]),
            .crc_q     (lane_crc[g]),
            .err_q     (lane_err[g])
        );
    end

    // Drive region outputs from the lanes
    always_comb begin
        ap_crc = lane_crc[REGION_AP];
        ff_crc = lane_crc[REGION_FF];
        ap_err = lane_err[REGION_AP];
        ff_err = lane_err[REGION_FF];
    end

    // R2
    fold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din >= 10'h3FC) |-> (folded == 10'h3FF));
endmodule

// File: tb/field_crc_pair_bench.sv
`timescale 1ns/1ps
module field_crc_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  din = '0;
    logic        ap_en = 1'b0, ff_en = 1'b0, field_end = 1'b0, tx_mode = 1'b0;
    logic [15:0] rx_ap_crc = '0, rx_ff_crc = '0;
    logic        rx_ap_valid = 1'b0, rx_ff_valid = 1'b0;
    logic [15:0] ap_crc, ff_crc;
    logic        ap_err, ff_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    logic [15:0] m_ap = '0, m_ff = '0;
    logic [15:0] e_ap = '0, e_ff = '0;
    logic        e_aerr = 1'b0, e_ferr = 1'b0;

    always #2.5 clk = ~clk;

    field_crc_pair u_field_crc_pair (
        .clk(clk), .rst_n(rst_n), .din(din), .ap_en(ap_en), .ff_en(ff_en),
        .field_end(field_end), .tx_mode(tx_mode),
        .rx_ap_crc(rx_ap_crc), .rx_ap_valid(rx_ap_valid),
        .rx_ff_crc(rx_ff_crc), .rx_ff_valid(rx_ff_valid),
        .ap_crc(ap_crc), .ff_crc(ff_crc), .ap_err(ap_err), .ff_err(ff_err)
    );

    function automatic logic [15:0] step(input logic [15:0] c_in, input logic [9:0] w_in);
        logic [15:0] c;
        logic [9:0]  w;
        logic        fb;
        c = c_in;
        w = (w_in >= 10'h3FC) ? 10'h3FF : w_in;
        for (int i = 0; i < 10; i++) begin
            fb = w[i] ^ c[15];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update model, sample at next falling edge
    task automatic push(input logic [9:0] w, input logic a, input logic f, input logic fe,
                        input logic tx, input logic [15:0] ra, input logic va,
                        input logic [15:0] rf, input logic vf);
        logic [15:0] na, nf;
        din = w; ap_en = a; ff_en = f; field_end = fe; tx_mode = tx;
        rx_ap_crc = ra; rx_ap_valid = va; rx_ff_crc = rf; rx_ff_valid = vf;
        na = a ? step(m_ap, w) : m_ap;
        nf = f ? step(m_ff, w) : m_ff;
        if (fe) begin
            e_ap = na; e_ff = nf;
            m_ap = '0; m_ff = '0;
        end else begin
            m_ap = na; m_ff = nf;
        end
        if (tx) begin
            e_aerr = 1'b0; e_ferr = 1'b0;
        end else if (fe) begin
            e_aerr = va && (na != ra);
            e_ferr = vf && (nf != rf);
        end
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " ap_crc"}, ap_crc, e_ap);
        chk({tag, " ff_crc"}, ff_crc, e_ff);
        chk({tag, " ap_err"}, {15'd0, ap_err}, {15'd0, e_aerr});
        chk({tag, " ff_err"}, {15'd0, ff_err}, {15'd0, e_ferr});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] pre_ff, pre_ap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check_all("R9 reset");

        // R1 R4 R6 R7: one-word fields over every word value, strobe on the data word
        for (int v = 0; v < 1024; v++) begin
            pre_ff = step(16'h0000, v[9:0]);
            pre_ap = v[0] ? pre_ff : 16'h0000;
            push(v[9:0], v[0], 1'b1, 1'b1, 1'b0,
                 ~pre_ap, v[1], pre_ff ^ {15'd0, v[2]}, 1'b1);
            check_all("R1 R4 R6 R7 sweep");
        end

        // R2: folded band matches the all-ones word
        for (int v = 1020; v < 1024; v++) begin
            push(v[9:0], 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
            chk("R2 fold ff", ff_crc, step(16'h0000, 10'h3FF));
            chk("R2 fold ap", ap_crc, step(16'h0000, 10'h3FF));
        end
        push(10'h3FB, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
        chk("R2 below band", {15'd0, ff_crc == step(16'h0000, 10'h3FF)}, 16'd0);

        // R1 R3 R5: long field, partial active region, outputs held mid-field
        for (int i = 0; i < 300; i++) begin
            push(10'((i * 37 + 5) % 1024), (i >= 50 && i < 250), 1'b1, 1'b0, 1'b0,
                 '0, 1'b0, '0, 1'b0);
            if (i % 50 == 7) check_all("R5 hold");
        end
        push(10'h155, 1'b0, 1'b0, 1'b1, 1'b0, m_ap, 1'b1, m_ff ^ 16'h0001, 1'b1);
        check_all("R1 R3 long field");

        // R3: fully disabled field yields zero
        for (int i = 0; i < 8; i++) push(10'(i * 91), 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        push(10'h2AA, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1234, 1'b1, 16'h0000, 1'b1);
        check_all("R3 disabled words");

        // R8: strobe in transmit mode with mismatching valid words
        push(10'h0F0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        push(10'h30F, 1'b1, 1'b1, 1'b1, 1'b1, 16'hDEAD, 1'b1, 16'hBEEF, 1'b1);
        check_all("R8 tx strobe");
        // raise flags in receive, then clear with transmit and no strobe
        push(10'h011, 1'b1, 1'b1, 1'b1, 1'b0, 16'hDEAD, 1'b1, 16'hBEEF, 1'b1);
        check_all("R6 set flags");
        push(10'h022, 1'b1, 1'b1, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0);
        check_all("R8 tx clear");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule